// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block moves 8-bit characters in both directions at once over a three-wire clocked serial link: a shift clock, a data output and a data input. Software-side logic writes a character into a one-deep transmit holding register. The block moves it into a transmit shift register and shifts it out least significant bit first. Each edge of the same shift clock also assembles the incoming bits into a receive shift register. After the eighth bit, that register is copied into a receive holding register that the host reads.

In internal-clock mode the block produces the shift clock itself. A source-tick generator selects full rate, one tick in eight, or a programmable even division. A half-period counter follows it. A high level on the clear-to-send input, or a cleared transmit enable, keeps a new character from starting, so the clock rests at its idle level between characters. In external-clock mode the shift clock arrives on an input pin, passes through a two-flop synchroniser, and the divider is not used.

Control is a FSM with four named states: OFF, IDLE, LEAD and TRAIL. OFF→IDLE occurs when the mode field reads synchronous. IDLE→LEAD (load) occurs when a held character may start. LEAD→TRAIL (sample) occurs on the trailing edge of bits 0 to 6, and on the last trailing edge in internal mode. LEAD→IDLE (finish) occurs on the last trailing edge in external mode. TRAIL→LEAD (shift) occurs on the next leading edge, or as a back-to-back load after bit 7. TRAIL→IDLE (finish) occurs half a period after bit 7 when nothing is queued. Any state goes to OFF when the mode field is not synchronous.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `buf_empty`=1, `shift_empty`=1, `rx_full`=0, `txd`=1, and `sclk_out` sits at its idle level (1 when `clk_pol`=0).
- R2: In internal mode, every half period of `sclk_out` lasts P*(`brg_m`+1) clock cycles. P is set by `src_sel`: 0→1, 1→8, 2→2*(`pdiv`+1), 3→1.
- R3: With `clk_pol`=0 the clock idles high, and its falling (leading) edge changes `txd` while its rising (trailing) edge samples `rxd`. With `clk_pol`=1 both levels and edges are inverted.
- R4: Bits leave on `txd` bit 0 first and bit 7 last. Received bits fill `rd_data` in the same order, so the first bit received lands in bit 0.
- R5: A character starts by moving the holding register into the shift register, which sets `buf_empty`. `shift_empty` is 0 for the whole character. It returns to 1 half a period after the last trailing edge in internal mode, and at the last trailing edge in external mode.
- R6: When a new character is written before the current one ends, it follows with no gap: every half period stays P*(`brg_m`+1) cycles. A write in the same cycle as a load is kept as the next character.
- R7: While `cts_in`=1 or `tx_en`=0, no character starts in internal mode, and `sclk_out` stays idle with the character still held.
- R8: With `irq_mode`=0, `tx_irq` pulses for one cycle when a load empties the holding register, while `shift_empty`=0. With `irq_mode`=1, it pulses in the cycle `shift_empty` returns to 1.
- R9: When `rx_en`=1, the eighth trailing edge copies the character to `rd_data`, sets `rx_full` and pulses `rx_irq`. `rd_en` clears `rx_full`, but a completion in the same cycle wins. When `rx_en`=0, `rd_data` and `rx_full` are left unchanged.
- R10: Any `mode` value other than 3'b001 aborts the character in flight. It forces `buf_empty`=1, `shift_empty`=1, `rx_full`=0 and an idle `sclk_out`. Writes are ignored while it holds.
- R11: With `clk_int`=0, the shift events follow `sclk_in` through a two-flop synchroniser, and `sclk_out` is held at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode | input | 3 | 3'b001 synchronous, anything else off |
| tx_en | input | 1 | allows characters to start |
| rx_en | input | 1 | allows received bits to be kept |
| clk_int | input | 1 | 1 internal shift clock, 0 external |
| clk_pol | input | 1 | shift-clock polarity |
| src_sel | input | 2 | count-source select |
| pdiv | input | 4 | programmable source divide value |
| brg_m | input | 8 | half-period divide value |
| irq_mode | input | 1 | 0 interrupt on buffer empty, 1 on complete |
| cts_in | input | 1 | high holds new characters |
| wr_en | input | 1 | write strobe for transmit holding register |
| wr_data | input | 8 | character to send |
| rd_en | input | 1 | read strobe, clears `rx_full` |
| rd_data | output | 8 | receive holding register |
| sclk_in | input | 1 | external shift clock |
| sclk_out | output | 1 | generated shift clock |
| rxd | input | 1 | serial data in |
| txd | output | 1 | serial data out |
| buf_empty | output | 1 | transmit holding register empty |
| shift_empty | output | 1 | transmit shift register idle |
| rx_full | output | 1 | unread character present |
| tx_irq | output | 1 | transmit interrupt strobe |
| rx_irq | output | 1 | receive interrupt strobe |

## Verification
The host read that clears `rx_full` can land in the same cycle as the eighth trailing edge that sets it. The bench provokes this by holding `rd_en` high through a whole character. Completion must win, so `rx_full` must be seen high in exactly one sampled cycle, and the character must still be readable afterwards. A write arriving in the same cycle the holding register is loaded is provoked the same way, by overlapping two writes with the start edge. It is judged by the second character following with no gap.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_LEAD  = 2'd2,
        ST_TRAIL = 2'd3
    } ssp_state_t;

    localparam logic [2:0] MODE_SYNC = 3'b001;
    localparam logic [1:0] SRC_F1    = 2'd0;
    localparam logic [1:0] SRC_F8    = 2'd1;
    localparam logic [1:0] SRC_FN    = 2'd2;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int M_W    = 8,
    parameter int PD_W   = 4,
    parameter int F8_DIV = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [1:0]      src_sel,
    input  logic [PD_W-1:0] pdiv,
    input  logic [M_W-1:0]  brg_m,
    output logic            half_tick
);
    import ssp_pkg::*;

    localparam int F8_W = $clog2(F8_DIV);
    localparam int SC_W = (PD_W + 1 > F8_W) ? PD_W + 1 : F8_W;

    logic [SC_W-1:0] sc, sc_last;
    logic [M_W-1:0]  hc;
    logic            src_tick;

    // last count of the source-tick counter for each source
    always_comb begin
        case (src_sel)
            SRC_F8:  sc_last = SC_W'(F8_DIV - 1);
            SRC_FN:  sc_last = SC_W'({pdiv, 1'b1});
            default: sc_last = '0;
        endcase
    end

    assign src_tick  = (sc >= sc_last);
    assign half_tick = src_tick && (hc >= brg_m);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc <= '0;
            hc <= '0;
        end else if (clr) begin
            sc <= '0;
            hc <= '0;
        end else begin
            sc <= src_tick ? '0 : sc + 1'b1;
            if (src_tick)
                hc <= (hc >= brg_m) ? '0 : hc + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic lead_ev,
    output logic trail_ev
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // leading edge moves the pin to the active level, which equals pol
    assign lead_ev  = (s2 != s3) && (s2 == pol);
    assign trail_ev = (s2 != s3) && (s2 != pol);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int M_W    = 8,
    parameter int PD_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              clk_int,
    input  logic              clk_pol,
    input  logic [1:0]        src_sel,
    input  logic [PD_W-1:0]   pdiv,
    input  logic [M_W-1:0]    brg_m,
    input  logic              irq_mode,
    input  logic              cts_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              rxd,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              rx_full,
    output logic              tx_irq,
    output logic              rx_irq
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    ssp_state_t        state, nstate;
    logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh, rx_buf;
    logic [CNT_W-1:0]  bitcnt;
    logic              active, half_tick, lead_ev, trail_ev, gen_clr;
    logic              sync_on, start_int, start_ext, last;
    logic              do_load, do_shift, do_sample, do_finish;

    assign sync_on   = (mode == MODE_SYNC);
    assign start_int = !buf_empty && tx_en && !cts_in;
    assign start_ext = !buf_empty && tx_en;
    assign last      = (bitcnt == CNT_W'(DATA_W - 1));
    assign gen_clr   = !(state == ST_LEAD || state == ST_TRAIL);

    ssp_clkgen #(.M_W(M_W), .PD_W(PD_W), .F8_DIV(8)) u_gen (
        .clk(clk), .rst_n(rst_n), .clr(gen_clr), .src_sel(src_sel),
        .pdiv(pdiv), .brg_m(brg_m), .half_tick(half_tick)
    );

    ssp_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk_in), .pol(clk_pol),
        .lead_ev(lead_ev), .trail_ev(trail_ev)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nstate;
    end

    // transitions: load, sample, shift, finish
    always_comb begin
        nstate    = state;
        do_load   = 1'b0;
        do_shift  = 1'b0;
        do_sample = 1'b0;
        do_finish = 1'b0;
        if (!sync_on) begin
            nstate = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: nstate = ST_IDLE;
                ST_IDLE: begin
                    if (clk_int ? start_int : (lead_ev && start_ext)) begin
                        do_load = 1'b1;
                        nstate  = ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (clk_int ? half_tick : trail_ev) begin
                        do_sample = 1'b1;
                        if (!clk_int && last) begin
                            do_finish = 1'b1;
                            nstate    = ST_IDLE;
                        end else begin
                            nstate = ST_TRAIL;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (bitcnt == CNT_W'(DATA_W)) begin
                        if (half_tick) begin
                            if (start_int) begin
                                do_load = 1'b1;
                                nstate  = ST_LEAD;
                            end else begin
                                do_finish = 1'b1;
                                nstate    = ST_IDLE;
                            end
                        end
                    end else if (clk_int ? half_tick : lead_ev) begin
                        do_shift = 1'b1;
                        nstate   = ST_LEAD;
                    end
                end
                default: nstate = ST_OFF;
            endcase
        end
    end

    // datapath, flags and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf      <= '0;
            tx_sh       <= '0;
            rx_sh       <= '0;
            rx_buf      <= '0;
            bitcnt      <= '0;
            active      <= 1'b0;
            txd         <= 1'b1;
            buf_empty   <= 1'b1;
            shift_empty <= 1'b1;
            rx_full     <= 1'b0;
            tx_irq      <= 1'b0;
            rx_irq      <= 1'b0;
        end else begin
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
            if (!sync_on) begin
                bitcnt      <= '0;
                active      <= 1'b0;
                txd         <= 1'b1;
                buf_empty   <= 1'b1;
                shift_empty <= 1'b1;
                rx_full     <= 1'b0;
            end else begin
                if (rd_en) rx_full <= 1'b0;
                if (wr_en) begin
                    tx_buf    <= wr_data;
                    buf_empty <= 1'b0;
                end
                if (do_load) begin
                    txd         <= tx_buf[0];
                    tx_sh       <= tx_buf >> 1;
                    bitcnt      <= '0;
                    active      <= 1'b1;
                    shift_empty <= 1'b0;
                    if (!wr_en) begin
                        buf_empty <= 1'b1;
                        if (!irq_mode) tx_irq <= 1'b1;
                    end
                end
                if (do_shift) begin
                    txd    <= tx_sh[0];
                    tx_sh  <= tx_sh >> 1;
                    active <= 1'b1;
                end
                if (do_sample) begin
                    active <= 1'b0;
                    bitcnt <= bitcnt + 1'b1;
                    if (rx_en) begin
                        rx_sh <= {rxd, rx_sh[DATA_W-1:1]};
                        if (last) begin
                            rx_buf  <= {rxd, rx_sh[DATA_W-1:1]};
                            rx_full <= 1'b1;
                            rx_irq  <= 1'b1;
                        end
                    end
                end
                if (do_finish) begin
                    shift_empty <= 1'b1;
                    if (irq_mode) tx_irq <= 1'b1;
                end
            end
        end
    end

    assign sclk_out = (clk_int && active) ? clk_pol : ~clk_pol;
    assign rd_data  = rx_buf;

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_OFF) |-> (sclk_out == ~clk_pol)); // R3
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> !shift_empty); // R5
    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_int && state == ST_IDLE && cts_in) |=> (state != ST_LEAD)); // R7
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_on && rd_en && !(do_sample && last && rx_en)) |=> !rx_full); // R9
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |=> (buf_empty && shift_empty && !rx_full && !active)); // R10
endmodule

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {src_sel, pdiv, brg_m, clk_pol, data}
    localparam logic [22:0] VEC [NVEC] = '{
        {2'd0, 4'd0, 8'd1, 1'b0, 8'hA5},
        {2'd0, 4'd0, 8'd3, 1'b1, 8'h3C},
        {2'd1, 4'd0, 8'd0, 1'b0, 8'h01},
        {2'd2, 4'd1, 8'd1, 1'b1, 8'h80},
        {2'd3, 4'd0, 8'd2, 1'b0, 8'hFF},
        {2'd2, 4'd0, 8'd0, 1'b0, 8'h5A}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [2:0] mode = 3'b001;
    logic       tx_en = 1'b1, rx_en = 1'b1, clk_int = 1'b1, clk_pol = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] pdiv = 4'd0;
    logic [7:0] brg_m = 8'd1;
    logic       irq_mode = 1'b0, cts_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sclk_in = 1'b1, sclk_out, rxd, txd;
    logic       buf_empty, shift_empty, rx_full, tx_irq, rx_irq;
    logic       loop = 1'b1, rxd_drv = 1'b0;
    int         checks = 0, fails = 0;
    int         irq_n = 0, rxirq_n = 0, both_n = 0;
    logic       irq_se = 1'b0, irq_be = 1'b0;

    assign rxd = loop ? txd : rxd_drv;
    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en), .rx_en(rx_en),
        .clk_int(clk_int), .clk_pol(clk_pol), .src_sel(src_sel), .pdiv(pdiv),
        .brg_m(brg_m), .irq_mode(irq_mode), .cts_in(cts_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .rxd(rxd), .txd(txd), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .rx_full(rx_full), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        if (tx_irq) begin
            irq_n++;
            irq_se = shift_empty;
            irq_be = buf_empty;
        end
        if (rx_irq) rxirq_n++;
        if (rd_en && rx_full) both_n++;
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    function automatic int half_len(input logic [1:0] s, input logic [3:0] pd, input logic [7:0] m);
        int p;
        p = (s == 2'd1) ? 8 : (s == 2'd2) ? 2 * (int'(pd) + 1) : 1;
        return p * (int'(m) + 1);
    endfunction

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_idle(input string rq);
        int g;
        g = 0;
        while (shift_empty !== 1'b1 && g < 4000) begin
            @(negedge clk); g++;
        end
        chk(shift_empty === 1'b1, rq, "shift_empty at end", shift_empty, 1);
    endtask

    // watches n shift-clock edges, checks spacing, captures txd at trailing edges
    task automatic run_edges(input int n, input int h, input logic pol_a, input string rq,
                             output logic [15:0] got);
        logic prev;
        int since, e, guard;
        prev = sclk_out; since = 0; e = 0; guard = 0; got = '0;
        while (e < n && guard < 5000) begin
            @(negedge clk); since++; guard++;
            if (sclk_out !== prev) begin
                if (e > 0) chk(since == h, rq, "half period", since, h);
                else chk(sclk_out == pol_a, "R3", "leading level", sclk_out, pol_a);
                if (e % 2 == 1) got[e/2] = txd;
                prev = sclk_out; since = 0; e++;
            end
        end
        if (e < n) chk(1'b0, rq, "edge count", e, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        summary();
    end

    initial begin
        logic [15:0] got;
        logic [7:0]  pat;
        int          h;
        repeat (4) @(negedge clk);
        chk(buf_empty == 1'b1 && shift_empty == 1'b1 && rx_full == 1'b0, "R1", "flags in reset",
            {buf_empty, shift_empty, rx_full}, 3'b110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(buf_empty == 1'b1 && shift_empty == 1'b1 && rx_full == 1'b0, "R1", "flags after reset",
            {buf_empty, shift_empty, rx_full}, 3'b110);
        chk(sclk_out == 1'b1 && txd == 1'b1, "R1", "idle pins", {sclk_out, txd}, 2'b11);

        // vector table: R2, R3, R4, R5, R9 over several sources and polarities
        for (int v = 0; v < NVEC; v++) begin
            src_sel = VEC[v][22:21]; pdiv = VEC[v][20:17]; brg_m = VEC[v][16:9];
            clk_pol = VEC[v][8];
            h = half_len(VEC[v][22:21], VEC[v][20:17], VEC[v][16:9]);
            @(negedge clk);
            chk(sclk_out == ~clk_pol, "R3", "idle level", sclk_out, ~clk_pol);
            wr_byte(VEC[v][7:0]);
            run_edges(16, h, clk_pol, "R2", got);
            chk(got[7:0] == VEC[v][7:0], "R4", "txd bit order", got[7:0], VEC[v][7:0]);
            wait_idle("R5");
            chk(rx_full == 1'b1 && rd_data == VEC[v][7:0], "R9", "received char", rd_data, VEC[v][7:0]);
            rd_pulse();
            chk(rx_full == 1'b0, "R9", "read clears", rx_full, 0);
        end

        src_sel = 2'd0; pdiv = 4'd0; brg_m = 8'd1; clk_pol = 1'b0;
        @(negedge clk);

        // R8 interrupt on buffer empty
        irq_mode = 1'b0; irq_n = 0;
        wr_byte(8'h6E);
        run_edges(16, 2, 1'b0, "R8", got);
        wait_idle("R8");
        repeat (4) @(negedge clk);
        chk(irq_n == 1 && irq_se == 1'b0 && irq_be == 1'b1, "R8", "mode0 irq",
            {irq_n[3:0], irq_se, irq_be}, 6'b000101);
        rd_pulse();

        // R8 interrupt on completion
        irq_mode = 1'b1; irq_n = 0;
        wr_byte(8'h91);
        run_edges(16, 2, 1'b0, "R8", got);
        wait_idle("R8");
        repeat (4) @(negedge clk);
        chk(irq_n == 1 && irq_se == 1'b1, "R8", "mode1 irq", {irq_n[3:0], irq_se}, 5'b00011);
        irq_mode = 1'b0;
        rd_pulse();

        // R6 back to back, second write lands in the load cycle
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
        @(negedge clk); wr_data = 8'h2D;
        fork
            run_edges(32, 2, 1'b0, "R6", got);
            begin @(negedge clk); wr_en = 1'b0; end
        join
        chk(got == 16'h2DC3, "R6", "two chars", got, 16'h2DC3);
        wait_idle("R6");
        chk(rd_data == 8'h2D, "R6", "last char received", rd_data, 8'h2D);
        rd_pulse();

        // R9 read held through completion
        rxirq_n = 0; both_n = 0;
        wr_byte(8'hB4);
        rd_en = 1'b1;
        run_edges(16, 2, 1'b0, "R9", got);
        wait_idle("R9");
        @(negedge clk); rd_en = 1'b0;
        chk(both_n == 1, "R9", "completion beats read", both_n, 1);
        chk(rx_full == 1'b0 && rd_data == 8'hB4 && rxirq_n == 1, "R9", "data after collision",
            rd_data, 8'hB4);

        // R7 clear-to-send high
        cts_in = 1'b1;
        wr_byte(8'h77);
        repeat (40) @(negedge clk);
        chk(sclk_out == 1'b1 && shift_empty == 1'b1 && buf_empty == 1'b0, "R7", "cts hold",
            {sclk_out, shift_empty, buf_empty}, 3'b110);
        cts_in = 1'b0;
        run_edges(16, 2, 1'b0, "R7", got);
        chk(got[7:0] == 8'h77, "R7", "char after cts", got[7:0], 8'h77);
        wait_idle("R7");
        rd_pulse();

        // R7 transmit enable low
        tx_en = 1'b0;
        wr_byte(8'h99);
        repeat (40) @(negedge clk);
        chk(sclk_out == 1'b1 && buf_empty == 1'b0, "R7", "tx_en hold", {sclk_out, buf_empty}, 2'b10);
        tx_en = 1'b1;
        run_edges(16, 2, 1'b0, "R7", got);
        chk(got[7:0] == 8'h99, "R7", "char after enable", got[7:0], 8'h99);
        wait_idle("R7");
        rd_pulse();

        // R9 receive disabled: rd_data keeps 8'h99
        rx_en = 1'b0; rxirq_n = 0;
        wr_byte(8'h0F);
        run_edges(16, 2, 1'b0, "R9", got);
        wait_idle("R9");
        chk(rx_full == 1'b0 && rd_data == 8'h99 && rxirq_n == 0, "R9", "rx disabled",
            rd_data, 8'h99);
        rx_en = 1'b1;

        // R10 abort mid character
        wr_byte(8'h42);
        run_edges(16, 2, 1'b0, "R10", got);
        wait_idle("R10");
        wr_byte(8'hF0);
        repeat (6) @(negedge clk);
        chk(shift_empty == 1'b0, "R10", "char in flight", shift_empty, 0);
        mode = 3'b000;
        repeat (2) @(negedge clk);
        chk(buf_empty == 1'b1 && shift_empty == 1'b1 && rx_full == 1'b0 && sclk_out == 1'b1,
            "R10", "off clears", {buf_empty, shift_empty, rx_full, sclk_out}, 4'b1101);
        wr_byte(8'h11);
        mode = 3'b001;
        repeat (30) @(negedge clk);
        chk(buf_empty == 1'b1 && sclk_out == 1'b1, "R10", "write while off ignored",
            {buf_empty, sclk_out}, 2'b11);

        // R11 external clock
        clk_int = 1'b0; loop = 1'b0; pat = 8'h39; got = '0;
        wr_byte(8'hC6);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0; rxd_drv = pat[i];
            repeat (6) @(negedge clk);
            got[i] = txd;
            chk(sclk_out == 1'b1, "R11", "sclk_out held idle", sclk_out, 1);
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk(got[7:0] == 8'hC6, "R11", "external tx", got[7:0], 8'hC6);
        chk(rx_full == 1'b1 && rd_data == 8'h39 && shift_empty == 1'b1, "R11", "external rx",
            rd_data, 8'h39);

        summary();
    end
endmodule